// File: doc/BRIEF.md
# Stepped Two-Operand ALU Sequencer

This block is the control and data path of a small calculator that a person steps through by hand. A single-cycle step pulse, already debounced upstream, moves a four-phase cycle forward. In the first phase an 8-bit value from a shared input bus is held as operand A. In the second phase the same bus supplies operand B. In the third phase the result of a combinational ALU is shown. In the fourth phase the display is blanked. The current phase is reported as a one-hot vector.

The ALU works on the two stored operands and a 3-bit opcode. It offers add, subtract, AND, OR and a signed set-less-than. It reports negative, zero, carry and overflow flags. The outputs give a display value with a source code for it, plus a blank flag. A display driver downstream converts these to digits. The block has one synchronous master reset.

Top module: `step_alu_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes load-A (`phase` = 0001) and both operands become zero. Directly after reset, `disp_val` is 0 and `disp_src` is 00.
- R2: Each rising edge of `step` advances the phase one place through 0001 → 0010 → 0100 → 1000 → 0001. The change appears at the clock edge where `step` is first seen high.
- R3: `phase` always has exactly one bit set.
- R4: If `step` stays high for several cycles, the phase advances once. With `step` low, the phase does not change.
- R5: Operand A is loaded from `din` only on the step that enters load-A (from the blank phase). Operand B is loaded only on the step that enters load-B. At all other times the bus has no effect on either operand.
- R6: `disp_src` and `disp_val` follow the phase. Load-A gives 00 with operand A. Load-B gives 01 with operand B. The result phase gives 10 with the ALU result. The blank phase gives 11 with `disp_val` = 0 and `blank` = 1. `blank` is 0 in every other phase.
- R7: Opcode 000 gives A+B, with carry equal to the unsigned carry out. Opcode 001 gives A−B, with carry = 1 when there is no borrow (A ≥ B unsigned). For both, overflow is the two's complement overflow.
- R8: Opcode 010 gives A AND B, and 011 gives A OR B. Opcode 101 gives 1 when A < B as signed values and 0 otherwise. Opcodes 100, 110 and 111 give 0. For every opcode except 000 and 001, carry and overflow are 0.
- R9: `nzcv` is {N, Z, C, V}, where bit 3 is N. N equals result bit 7, and Z is 1 exactly when the result is 0.
- R10: A reset in the middle of a cycle returns the block to the R1 state, whatever phase it was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| step | input | 1 | Debounced step request |
| din | input | 8 | Shared operand bus, two's complement |
| opcode | input | 3 | ALU operation select |
| phase | output | 4 | One-hot phase: load-A, load-B, result, blank |
| disp_src | output | 2 | Source of the display value |
| disp_val | output | 8 | Value to display |
| blank | output | 1 | Display blank request |
| nzcv | output | 4 | ALU flags {N, Z, C, V} |

## Verification
A phase register that is wrong shows on `phase` and `disp_src` at the first sample after the edge that caused it. A corrupted operand shows in the load phase that displays it, or in the next result phase as a wrong value or wrong flags. Both happen within four steps. An operand that is overwritten outside its load step shows as soon as that operand is displayed again. This is why the bench changes `din` while no step occurs and then reads the operands back through the display.

// File: rtl/step_alu_seq.sv
module step_alu_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] din,
  input  logic [2:0]   opcode,
  output logic [3:0]   phase,
  output logic [1:0]   disp_src,
  output logic [W-1:0] disp_val,
  output logic         blank,
  output logic [3:0]   nzcv
);

  logic [3:0]   ph_q;
  logic         step_q;
  logic [W-1:0] a_q, b_q;
  logic         adv;

  assign adv = step & ~step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 4'b0001;
      step_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      step_q <= step;
      if (adv) begin
        ph_q <= {ph_q[2:0], ph_q[3]};
        if (ph_q[3]) a_q <= din;
        if (ph_q[0]) b_q <= din;
      end
    end
  end

  logic [W:0]   sum_w, dif_w;
  logic         add_ov, sub_ov;
  logic [W-1:0] res;
  logic         c_f, v_f;

  assign sum_w  = {1'b0, a_q} + {1'b0, b_q};
  assign dif_w  = {1'b0, a_q} + {1'b0, ~b_q} + (W+1)'(1);
  assign add_ov = (a_q[W-1] == b_q[W-1]) && (sum_w[W-1] != a_q[W-1]);
  assign sub_ov = (a_q[W-1] != b_q[W-1]) && (dif_w[W-1] != a_q[W-1]);

  always_comb begin
    res = '0;
    c_f = 1'b0;
    v_f = 1'b0;
    case (opcode)
      3'b000: begin res = sum_w[W-1:0]; c_f = sum_w[W]; v_f = add_ov; end
      3'b001: begin res = dif_w[W-1:0]; c_f = dif_w[W]; v_f = sub_ov; end
      3'b010: res = a_q & b_q;
      3'b011: res = a_q | b_q;
      3'b101: res = {{(W-1){1'b0}}, dif_w[W-1] ^ sub_ov};
      default: res = '0;
    endcase
  end

  assign nzcv  = {res[W-1], res == '0, c_f, v_f};
  assign phase = ph_q;
  assign blank = ph_q[3];

  always_comb begin
    if (ph_q[0])      disp_src = 2'b00;
    else if (ph_q[1]) disp_src = 2'b01;
    else if (ph_q[2]) disp_src = 2'b10;
    else              disp_src = 2'b11;
  end

  always_comb begin
    case (disp_src)
      2'b00:   disp_val = a_q;
      2'b01:   disp_val = b_q;
      2'b10:   disp_val = res;
      default: disp_val = '0;
    endcase
  end

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !step_q) |=> phase == {$past(phase[2:0]), $past(phase[3])});

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(step && !step_q) |=> $stable(phase));

  assert_a_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(step && !step_q && phase[3]) |=> $stable(a_q));

  assert_b_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(step && !step_q && phase[0]) |=> $stable(b_q));

  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    blank |-> (disp_src == 2'b11 && disp_val == '0));

  assert_cv_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (opcode[2:1] != 2'b00) |-> (nzcv[1:0] == 2'b00));

  assert_zflag_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_src == 2'b10) |-> (nzcv[2] == (disp_val == '0)));

endmodule

// File: tb/step_alu_seq_bench.sv
module step_alu_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic [7:0] din = '0;
  logic [2:0] opcode = '0;
  logic [3:0] phase;
  logic [1:0] disp_src;
  logic [7:0] disp_val;
  logic blank;
  logic [3:0] nzcv;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  step_alu_seq u_step_alu_seq (
    .clk(clk), .rst(rst), .step(step), .din(din), .opcode(opcode),
    .phase(phase), .disp_src(disp_src), .disp_val(disp_val),
    .blank(blank), .nzcv(nzcv)
  );

  // {opcode, a, b, result, nzcv}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {3'b000, 8'h05, 8'h03, 8'h08, 4'b0000},
    {3'b000, 8'h7F, 8'h01, 8'h80, 4'b1001},
    {3'b000, 8'hFF, 8'h01, 8'h00, 4'b0110},
    {3'b000, 8'h80, 8'h80, 8'h00, 4'b0111},
    {3'b001, 8'h05, 8'h03, 8'h02, 4'b0010},
    {3'b001, 8'h03, 8'h05, 8'hFE, 4'b1000},
    {3'b001, 8'h80, 8'h01, 8'h7F, 4'b0011},
    {3'b001, 8'h22, 8'h22, 8'h00, 4'b0110},
    {3'b010, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {3'b011, 8'hF0, 8'h0F, 8'hFF, 4'b1000},
    {3'b010, 8'h0F, 8'hF0, 8'h00, 4'b0100},
    {3'b101, 8'hFE, 8'h01, 8'h01, 4'b0000},
    {3'b101, 8'h05, 8'hFB, 8'h00, 4'b0100},
    {3'b101, 8'h80, 8'h7F, 8'h01, 4'b0000},
    {3'b101, 8'h7F, 8'h80, 8'h00, 4'b0100},
    {3'b110, 8'h12, 8'h34, 8'h00, 4'b0100}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 phase", {4'b0, phase}, 8'h01);
    chk("R1 disp_val", disp_val, 8'h00);
    chk("R1 disp_src", {6'b0, disp_src}, 8'h00);
    chk("R6 blank off", {7'b0, blank}, 8'h00);

    din = 8'hAA;
    pulse();
    chk("R2 to loadB", {4'b0, phase}, 8'h02);
    chk("R5 B loaded", disp_val, 8'hAA);
    pulse();
    chk("R2 to result", {4'b0, phase}, 8'h04);
    pulse();
    chk("R2 to blank", {4'b0, phase}, 8'h08);
    chk("R6 blank on", {7'b0, blank}, 8'h01);
    chk("R6 blank src", {6'b0, disp_src}, 8'h03);
    chk("R6 blank val", disp_val, 8'h00);

    for (int i = 0; i < NV; i++) begin
      din = VEC[i][27:20];
      pulse();
      chk("R2 vec loadA", {4'b0, phase}, 8'h01);
      chk("R6 vec A", disp_val, VEC[i][27:20]);
      din = VEC[i][19:12];
      pulse();
      chk("R6 vec B", disp_val, VEC[i][19:12]);
      chk("R6 vec src B", {6'b0, disp_src}, 8'h01);
      opcode = VEC[i][30:28];
      din = 8'h5A;
      pulse();
      chk("R7 R8 vec result", disp_val, VEC[i][11:4]);
      chk("R9 vec nzcv", {4'b0, nzcv}, {4'b0, VEC[i][3:0]});
      chk("R6 vec src res", {6'b0, disp_src}, 8'h02);
      pulse();
      chk("R3 vec blank phase", {4'b0, phase}, 8'h08);
    end

    din = 8'h11;
    pulse();
    din = 8'h22;
    @(negedge clk) step = 1'b1;
    repeat (5) @(negedge clk);
    step = 1'b0;
    #1;
    chk("R4 held step", {4'b0, phase}, 8'h02);
    din = 8'h99;
    repeat (6) @(negedge clk);
    #1;
    chk("R4 idle phase", {4'b0, phase}, 8'h02);
    chk("R5 B kept", disp_val, 8'h22);
    opcode = 3'b000;
    pulse();
    chk("R5 A kept sum", disp_val, 8'h33);
    pulse();
    din = 8'h44;
    pulse();
    chk("R5 A reloaded", disp_val, 8'h44);
    pulse();
    chk("R5 B from bus", disp_val, 8'h44);
    pulse();
    chk("R3 result phase", {4'b0, phase}, 8'h04);

    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R10 phase", {4'b0, phase}, 8'h01);
    chk("R10 A cleared", disp_val, 8'h00);
    din = 8'h77;
    pulse();
    chk("R10 B cleared then loaded", disp_val, 8'h77);
    pulse();
    chk("R10 A zero sum", disp_val, 8'h77);

    summary();
  end
endmodule